// File: doc/BRIEF.md
# Byte-Lane Data Memory with Optional Byte Reversal

This block is a single-port data store of 64-bit words. It serves loads and stores of 1, 2, 4 or 8 bytes at byte addresses. The low three address bits give a byte offset inside a word, and the remaining bits select the word. A narrow load shifts the addressed lane down to bit 0 and clears the bits above it. A narrow store merges the new lane into the stored word and keeps every other byte of that word unchanged.

Each request can also ask for its data to be byte-reversed within the access width. On a store the reversal happens before the lane is inserted. On a load it happens after the lane is extracted. This lets one array serve both byte orders.

A request whose offset is not a multiple of its width is refused. The memory is left untouched and a one-cycle error pulse follows. Load data is registered and appears one cycle after the request.

Top module: `bytelane_mem`

## Requirements
- R1: The byte address splits into a word index (address shifted right by 3) and a byte offset (address bits 2:0). The size code on `req_size` is the log2 of the width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes.
- R2: A request whose offset is not a multiple of its width leaves memory unchanged. In the next cycle it raises `rsp_err` for exactly one cycle, with `rsp_valid` low and `rsp_rdata` unchanged.
- R3: An aligned load narrower than 8 bytes returns, from bit 0 upward, the bytes of the word starting at the offset, with every bit above the width zero.
- R4: An aligned 8-byte load returns the whole addressed word.
- R5: An aligned store narrower than 8 bytes replaces only the addressed byte lane. The other bytes of the word are preserved, and bits of `req_wdata` above the width are ignored.
- R6: An aligned 8-byte store replaces the whole addressed word.
- R7: With `req_swap` high, a store reverses the byte order of the low width bytes of `req_wdata` before inserting them.
- R8: With `req_swap` high, a load reverses the byte order of the extracted lane within the width. Bits above the width stay zero.
- R9: `rsp_valid` is high exactly in the cycle after an accepted load, and `rsp_rdata` then holds its result. After stores, refused requests and idle cycles, `rsp_rdata` keeps its previous value.
- R10: Reset clears every word, `rsp_rdata`, `rsp_valid` and `rsp_err` to zero, so a word that has never been written reads as zero.
- R11: While `req_valid` is low, the other request inputs have no effect on memory or on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | log2 of the access width in bytes |
| req_we | input | 1 | 1 = store, 0 = load |
| req_swap | input | 1 | Byte-reverse data within the access width |
| req_wdata | input | 64 | Store data, right-aligned |
| rsp_rdata | output | 64 | Load result, right-aligned, zero-extended |
| rsp_valid | output | 1 | Load result valid (one cycle after the request) |
| rsp_err | output | 1 | Previous request was misaligned and refused |

## Verification
Directed cases come first. A freshly reset memory is read at several offsets to tell zero-fill apart from stale data. A full word of distinct bytes is read back at every width and offset, which separates correct lane selection from a wrong shift or mask. Narrow stores are sent with garbage in the upper write-data bits and with the swap flag set, to show that only the lane changes and that the reversal follows the access width rather than the word. Misaligned requests at each width, and idle cycles with noisy inputs, are followed by reads that prove nothing was written. A long seeded random mix of sizes, offsets, swap settings and directions over a few words is then checked against a byte-level model.

// File: rtl/blm_pkg.sv
package blm_pkg;
  localparam int WORD_BYTES = 8;
  localparam int WORD_W     = WORD_BYTES * 8;
  localparam int OFF_W      = $clog2(WORD_BYTES);
  localparam int SHAMT_W    = $clog2(WORD_W);
  localparam int SIZE_W     = 2;

  typedef enum logic [SIZE_W-1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_QUAD = 2'd2,
    SZ_FULL = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic [SHAMT_W-1:0] shamt;
    logic [WORD_W-1:0]  lane_mask;
    logic               aligned;
    logic               full;
  } lane_ctl_t;
endpackage

// File: rtl/blm_lane_ctrl.sv
module blm_lane_ctrl
  import blm_pkg::*;
(
  input  logic [OFF_W-1:0]  offset,
  input  logic [SIZE_W-1:0] size,
  output lane_ctl_t         ctl
);
  always_comb begin
    ctl.shamt = {offset, 3'b000};
    ctl.full  = 1'b0;
    unique case (acc_size_e'(size))
      SZ_BYTE: begin
        ctl.lane_mask = {{(WORD_W-8){1'b0}}, {8{1'b1}}};
        ctl.aligned   = 1'b1;
      end
      SZ_HALF: begin
        ctl.lane_mask = {{(WORD_W-16){1'b0}}, {16{1'b1}}};
        ctl.aligned   = (offset[0] == 1'b0);
      end
      SZ_QUAD: begin
        ctl.lane_mask = {{(WORD_W-32){1'b0}}, {32{1'b1}}};
        ctl.aligned   = (offset[1:0] == 2'b00);
      end
      default: begin
        ctl.lane_mask = {WORD_W{1'b1}};
        ctl.aligned   = (offset == '0);
        ctl.full      = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/blm_byte_rev.sv
module blm_byte_rev
  import blm_pkg::*;
(
  input  logic [WORD_W-1:0] din,
  input  logic [SIZE_W-1:0] size,
  input  logic              swap,
  output logic [WORD_W-1:0] dout
);
  localparam int NSIZE = 1 << SIZE_W;

  logic [WORD_W-1:0] rev [NSIZE];

  for (genvar g = 0; g < NSIZE; g++) begin : g_size
    localparam int NB = 1 << g;
    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
      if (b < NB) begin : g_in
        assign rev[g][8*b +: 8] = din[8*(NB-1-b) +: 8];
      end else begin : g_out
        assign rev[g][8*b +: 8] = 8'h00;
      end
    end
  end

  always_comb begin
    if (swap) dout = rev[size];
    else      dout = din;
  end
endmodule

// File: rtl/blm_word_array.sv
module blm_word_array
  import blm_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  assign rd_data = mem_q[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[idx] <= wr_data;
    end
  end
endmodule

// File: rtl/bytelane_mem.sv
module bytelane_mem
  import blm_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int ADDR_W = IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_we,
  input  logic              req_swap,
  input  logic [63:0]       req_wdata,
  output logic [63:0]       rsp_rdata,
  output logic              rsp_valid,
  output logic              rsp_err
);
  logic [OFF_W-1:0]  offset;
  logic [IDX_W-1:0]  word_idx;
  lane_ctl_t         ctl;
  logic [WORD_W-1:0] old_word;
  logic [WORD_W-1:0] lane_raw;
  logic [WORD_W-1:0] lane_out;
  logic [WORD_W-1:0] st_masked;
  logic [WORD_W-1:0] st_lane;
  logic [WORD_W-1:0] merged;
  logic              accept;
  logic              wr_en;

  logic [WORD_W-1:0] rdata_q, rdata_d;
  logic              valid_q, valid_d;
  logic              err_q,   err_d;
  logic              rdata_en;

  assign offset   = req_addr[OFF_W-1:0];
  assign word_idx = req_addr[ADDR_W-1:OFF_W];

  blm_lane_ctrl u_ctrl (
    .offset (offset),
    .size   (req_size),
    .ctl    (ctl)
  );

  blm_word_array #(.DEPTH(DEPTH)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .idx     (word_idx),
    .wr_data (merged),
    .rd_data (old_word)
  );

  // load path: shift lane down, clear above width, optional reversal
  assign lane_raw = (old_word >> ctl.shamt) & ctl.lane_mask;

  blm_byte_rev u_rev_ld (
    .din  (lane_raw),
    .size (req_size),
    .swap (req_swap),
    .dout (lane_out)
  );

  // store path: trim to width, optional reversal, then merge into word
  assign st_masked = req_wdata & ctl.lane_mask;

  blm_byte_rev u_rev_st (
    .din  (st_masked),
    .size (req_size),
    .swap (req_swap),
    .dout (st_lane)
  );

  always_comb begin
    if (ctl.full) merged = st_lane;
    else          merged = (old_word & ~(ctl.lane_mask << ctl.shamt))
                         | (st_lane << ctl.shamt);
  end

  assign accept = req_valid & ctl.aligned;
  assign wr_en  = accept & req_we;

  // next-state
  always_comb begin
    rdata_en = accept & ~req_we;
    valid_d  = rdata_en;
    err_d    = req_valid & ~ctl.aligned;
    rdata_d  = rdata_en ? lane_out : rdata_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  assign rsp_rdata = rdata_q;
  assign rsp_valid = valid_q;
  assign rsp_err   = err_q;
endmodule

// File: rtl/bytelane_mem_chk.sv
module bytelane_mem_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic              req_we,
  input logic [63:0]       rsp_rdata,
  input logic              rsp_valid,
  input logic              rsp_err
);
  logic misal;
  always_comb begin
    case (req_size)
      2'd0:    misal = 1'b0;
      2'd1:    misal = req_addr[0];
      2'd2:    misal = |req_addr[1:0];
      default: misal = |req_addr[2:0];
    endcase
  end

  AST_MISALIGN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && misal |=> rsp_err && !rsp_valid) else $error("misalign"); // R2
  AST_ERR_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> $stable(rsp_rdata)) else $error("err data"); // R2
  AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_we && !misal |=> rsp_valid && !rsp_err) else $error("latency"); // R9
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> $stable(rsp_rdata)) else $error("held"); // R9
  AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_we && req_size == 2'd0 |=> rsp_rdata[63:8] == '0) else $error("zext"); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_err) else $error("idle"); // R11
  AST_ONE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_valid, rsp_err})) else $error("onehot"); // R9
endmodule

bind bytelane_mem bytelane_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .req_size  (req_size),
  .req_we    (req_we),
  .rsp_rdata (rsp_rdata),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err)
);

// File: tb/bytelane_mem_bench.sv
module bytelane_mem_bench;
  localparam int DEPTH  = 256;
  localparam int ADDR_W = $clog2(DEPTH) + 3;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic [1:0]        req_size;
  logic              req_we;
  logic              req_swap;
  logic [63:0]       req_wdata;
  logic [63:0]       rsp_rdata;
  logic              rsp_valid;
  logic              rsp_err;

  int n_chk  = 0;
  int n_fail = 0;
  logic [63:0] model [DEPTH];
  logic [63:0] last_rd;

  bytelane_mem #(.DEPTH(DEPTH)) u_bytelane_mem (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_we(req_we), .req_swap(req_swap),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [63:0] f_mask(input int sz);
    if (sz == 3) return '1;
    return (64'd1 << (8 << sz)) - 64'd1;
  endfunction

  function automatic logic [63:0] f_rev(input logic [63:0] d, input int sz);
    logic [63:0] r = '0;
    int nb = 1 << sz;
    for (int i = 0; i < nb; i++) r[8*i +: 8] = d[8*(nb-1-i) +: 8];
    return r;
  endfunction

  function automatic logic [63:0] f_load(input int a, input int sz, input bit sw);
    logic [63:0] w = model[a >> 3];
    logic [63:0] v = (w >> (8 * (a & 7))) & f_mask(sz);
    return sw ? f_rev(v, sz) : v;
  endfunction

  function automatic bit f_ok(input int a, input int sz);
    return ((a & 7) % (1 << sz)) == 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one request, result sampled at the following negedge
  task automatic do_req(input int a, input int sz, input bit we, input bit sw,
                        input logic [63:0] wd, input string tag);
    bit ok = f_ok(a, sz);
    logic [63:0] exp_rd = last_rd;
    logic [63:0] d;
    int sh;
    if (ok && !we) exp_rd = f_load(a, sz, sw);
    @(negedge clk);
    req_valid = 1'b1; req_addr = ADDR_W'(a); req_size = 2'(sz);
    req_we = we; req_swap = sw; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (ok && we) begin
      d = wd & f_mask(sz);
      if (sw) d = f_rev(d, sz);
      sh = 8 * (a & 7);
      model[a >> 3] = (model[a >> 3] & ~(f_mask(sz) << sh)) | (d << sh);
    end
    chk(rsp_err == !ok, {tag, " err"}, 64'(rsp_err), 64'(!ok));
    chk(rsp_valid == (ok && !we), {tag, " valid"}, 64'(rsp_valid), 64'(ok && !we));
    chk(rsp_rdata == exp_rd, {tag, " data"}, rsp_rdata, exp_rd);
    last_rd = exp_rd;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    last_rd = '0;
    req_valid = 0; req_addr = '0; req_size = 0; req_we = 0; req_swap = 0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(rsp_rdata == 0 && !rsp_valid && !rsp_err, "R10 reset outputs", rsp_rdata, 64'd0);
    do_req(0, 3, 0, 0, 0, "R10 unwritten word");
    do_req(8*200+6, 1, 0, 0, 0, "R10 unwritten half");
    // R6/R4 full store and load
    do_req(8*3, 3, 1, 0, 64'h8877_6655_4433_2211, "R6 full store");
    do_req(8*3, 3, 0, 0, 0, "R4 full load");
    // R1/R3 lane selection at every width
    for (int o = 0; o < 8; o++) do_req(8*3+o, 0, 0, 0, 0, "R3 byte lane R1");
    for (int o = 0; o < 8; o += 2) do_req(8*3+o, 1, 0, 0, 0, "R3 half lane");
    do_req(8*3+4, 2, 0, 0, 0, "R3 quad lane");
    // R5 narrow store with garbage high bits
    do_req(8*3+5, 0, 1, 0, 64'hDEAD_BEEF_CAFE_F0AB, "R5 byte store");
    do_req(8*3, 3, 0, 0, 0, "R5 word after byte store");
    do_req(8*3+2, 1, 1, 0, 64'hFFFF_FFFF_FFFF_1234, "R5 half store");
    do_req(8*3, 3, 0, 0, 0, "R5 word after half store");
    // R7/R8 swap
    do_req(8*4+4, 2, 1, 1, 64'h0000_0000_A1B2_C3D4, "R7 swapped quad store");
    do_req(8*4, 3, 0, 0, 0, "R7 word after swapped store");
    do_req(8*4+4, 2, 0, 1, 0, "R8 swapped quad load");
    do_req(8*3+6, 1, 0, 1, 0, "R8 swapped half load");
    do_req(8*3, 3, 0, 1, 0, "R8 swapped full load");
    // R2 misaligned at each width
    do_req(8*3+1, 1, 1, 0, 64'hFFFF, "R2 half misaligned store");
    do_req(8*3+2, 2, 1, 0, 64'hFFFF_FFFF, "R2 quad misaligned store");
    do_req(8*3+4, 3, 1, 0, '1, "R2 full misaligned store");
    do_req(8*3+3, 2, 0, 0, 0, "R2 misaligned load");
    do_req(8*3, 3, 0, 0, 0, "R2 word unchanged");
    // R11 idle with noisy inputs
    @(negedge clk);
    req_valid = 0; req_we = 1; req_addr = ADDR_W'(8*3); req_size = 3; req_wdata = '1;
    @(negedge clk);
    chk(!rsp_valid && !rsp_err && rsp_rdata == last_rd, "R11 idle outputs", rsp_rdata, last_rd);
    do_req(8*3, 3, 0, 0, 0, "R11 word unchanged after idle");
    // random mix
    for (int k = 0; k < 3000; k++) begin
      int a = int'($urandom_range(0, 127));
      int sz = int'($urandom_range(0, 3));
      bit we = 1'($urandom_range(0, 1));
      bit sw = 1'($urandom_range(0, 1));
      logic [63:0] wd = {$urandom, $urandom};
      do_req(a, sz, we, sw, wd, "R1 R3 R5 R7 R8 random");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule